// File: doc/BRIEF.md
# PCI Target Cycle Controller

This block is the slave side of a 32-bit PCI bus interface. It watches the shared bus for the start of a cycle, latches the address, the command and the configuration select, and decodes the command into an access class: I/O, memory, configuration or interrupt acknowledge. The extended memory read commands are folded into plain memory read, and write-and-invalidate is folded into plain memory write. External address comparators look at the latched address and return hit flags. The block then claims the cycle with medium decode timing, or it leaves the bus alone.

A claimed cycle always moves exactly one data word. The block asserts target ready and stop in the same clock, so the initiator can never burst. Reads fetch their word from a register port one clock before target ready. Writes deliver the word and its byte enables to the register port in the clock after the transfer. The block drives data parity for reads and checks data parity for writes. It can check address parity and reports data parity errors when reporting is enabled. After the transfer it drives its control lines high for one turnaround clock and then releases them.

Top module: `pci_tgt_ctrl`

## Requirements
- R1: While a cycle is in progress, `acc_addr_o` holds the AD value sampled on the address-phase edge, which is the first rising edge at which `frame_ni` is low while the block is idle.
- R2: A cycle is claimed when its command maps to an access class that is enabled. The classes are I/O (0010, 0011) with `io_hit_i`, memory with `mem_hit_i`, configuration (1010, 1011) with `idsel_i` sampled in the address phase, and interrupt acknowledge (0000) with `inta_en_i`. `devsel_no` goes low after the second rising edge following the address phase.
- R3: Commands 0100, 0101, 1000, 1001, 1101 and the broadcast 0001 are never claimed, and neither is a cycle whose class is not enabled. For such a cycle `tgt_oe_o` stays low and `rd_o` and `wr_o` are never raised.
- R4: `acc_cmd_o` reports 1100 and 1110 as 0110 (memory read) and reports 1111 as 0111 (memory write). Other commands pass through unchanged. Bit 0 of the command selects write (1) or read (0).
- R5: `trdy_no` and `stop_no` go low together one clock after `devsel_no` goes low. `ad_oe_o` is high only while `trdy_no` is low on a read.
- R6: A word transfers only on an edge where `irdy_ni` and `trdy_no` are both low. While `irdy_ni` is high, `trdy_no` stays low and no write strobe is issued.
- R7: For a read, `rd_o` is high for exactly the clock in which `devsel_no` first goes low. `rd_data_i` is sampled at the end of that clock and appears on `ad_o`. In the clock after the transfer, `par_oe_o` is high and `par_o` is the even parity of that word together with the C/BE# value of the transfer.
- R8: For a write, `wr_o` is high for one clock, the clock after the transfer. `wr_data_o` holds the transferred word and `wr_be_o` holds the inverted C/BE# value of the transfer.
- R9: A write whose `par_i`, sampled one clock after the transfer, is not the even parity of the word and its C/BE# value drives `perr_no` low for one clock, two clocks after the transfer. This happens only when `perr_en_i` is high, and `perr_oe_o` covers that clock and the one after it.
- R10: `addr_perr_o` pulses for one clock when `par_chk_en_i` is high and the `par_i` sampled one clock after the address phase does not match the even parity of the address and the command. When `par_chk_en_i` is low it stays low.
- R11: In the clock after the transfer, `devsel_no`, `trdy_no` and `stop_no` are high with `tgt_oe_o` still high. In the clock after that, `tgt_oe_o` is low.
- R12: Out of reset, all output enables are low, `devsel_no`, `trdy_no`, `stop_no` and `perr_no` are high, and `rd_o`, `wr_o` and `addr_perr_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frame_ni | input | 1 | Cycle framing from the initiator, active low |
| irdy_ni | input | 1 | Initiator ready, active low |
| idsel_i | input | 1 | Configuration select |
| cbe_ni | input | 4 | Command in the address phase, byte enables in the data phase (active low) |
| ad_i | input | 32 | Address/data input |
| par_i | input | 1 | Parity input |
| ad_o | output | 32 | Read data driven to AD |
| ad_oe_o | output | 1 | Enable for ad_o |
| par_o | output | 1 | Read data parity |
| par_oe_o | output | 1 | Enable for par_o |
| devsel_no | output | 1 | Device select, active low |
| trdy_no | output | 1 | Target ready, active low |
| stop_no | output | 1 | Stop, active low |
| tgt_oe_o | output | 1 | Enable for devsel_no, trdy_no and stop_no |
| perr_no | output | 1 | Data parity error, active low |
| perr_oe_o | output | 1 | Enable for perr_no |
| addr_perr_o | output | 1 | Address parity error pulse |
| par_chk_en_i | input | 1 | Enable for the address parity check |
| perr_en_i | input | 1 | Enable for data parity error reporting |
| io_hit_i | input | 1 | I/O decoder hit on acc_addr_o |
| mem_hit_i | input | 1 | Memory decoder hit on acc_addr_o |
| inta_en_i | input | 1 | Respond to interrupt acknowledge |
| acc_addr_o | output | 32 | Latched cycle address |
| acc_cmd_o | output | 4 | Normalized command |
| rd_o | output | 1 | Register read strobe |
| rd_data_i | input | 32 | Register read data |
| wr_o | output | 1 | Register write strobe |
| wr_data_o | output | 32 | Register write data |
| wr_be_o | output | 4 | Register write byte enables, active high |

## Verification
The assertions assume a well-behaved initiator. It holds `perr_en_i` steady across a cycle, and it presents the hit inputs in the clock after the address phase, computed from `acc_addr_o`. It keeps `frame_ni` and `irdy_ni` high for at least one clock between cycles. The bench drives every cycle in that order, with configuration enables and hits set before the address phase. It deasserts framing together with the ready assertion and drops both once a cycle ends or is left unclaimed, so the assertions only ever see legal single-phase traffic.

// File: rtl/pci_tgt_pkg.sv
package pci_tgt_pkg;
  typedef enum logic [2:0] {
    SP_NONE, SP_INTA, SP_SPEC, SP_IO, SP_MEM, SP_CFG
  } space_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_DEC, ST_DEVS, ST_DATA, ST_TURN, ST_WAIT
  } tstate_e;
endpackage

// File: rtl/pci_cmd_decode.sv
module pci_cmd_decode
  import pci_tgt_pkg::*;
(
  input  logic [3:0] cmd_i,
  output space_e     space_o,
  output logic       is_wr_o,
  output logic [3:0] norm_o
);
  always_comb begin
    unique case (cmd_i)
      4'b0000:                                  space_o = SP_INTA;
      4'b0001:                                  space_o = SP_SPEC;
      4'b0010, 4'b0011:                         space_o = SP_IO;
      4'b0110, 4'b0111, 4'b1100,
      4'b1110, 4'b1111:                         space_o = SP_MEM;
      4'b1010, 4'b1011:                         space_o = SP_CFG;
      default:                                  space_o = SP_NONE;
    endcase
  end

  // extended memory commands collapse onto the basic pair
  always_comb begin
    unique case (cmd_i)
      4'b1100, 4'b1110: norm_o = 4'b0110;
      4'b1111:          norm_o = 4'b0111;
      default:          norm_o = cmd_i;
    endcase
  end

  assign is_wr_o = cmd_i[0];
endmodule

// File: rtl/pci_tgt_fsm.sv
module pci_tgt_fsm
  import pci_tgt_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic frame_ni,
  input  logic irdy_ni,
  input  logic claim_i,
  input  logic is_wr_i,
  output logic addr_ph_o,
  output logic dec_o,
  output logic xfer_o,
  output logic wchk_o,
  output logic devsel_no,
  output logic trdy_no,
  output logic stop_no,
  output logic tgt_oe_o,
  output logic rd_o,
  output logic wr_o,
  output logic ad_oe_o,
  output logic par_oe_o
);
  tstate_e state_q, state_d;

  assign addr_ph_o = (state_q == ST_IDLE) && !frame_ni;
  assign dec_o     = (state_q == ST_DEC);
  assign xfer_o    = (state_q == ST_DATA) && !irdy_ni;
  assign wchk_o    = (state_q == ST_TURN) && is_wr_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (!frame_ni) state_d = ST_DEC;
      ST_DEC:  state_d = claim_i ? ST_DEVS : ST_WAIT;
      ST_DEVS: state_d = ST_DATA;
      ST_DATA: if (!irdy_ni) state_d = ST_TURN;
      ST_TURN: state_d = ST_WAIT;
      ST_WAIT: if (frame_ni && irdy_ni) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign devsel_no = !((state_q == ST_DEVS) || (state_q == ST_DATA));
  assign trdy_no   = (state_q != ST_DATA);
  assign stop_no   = (state_q != ST_DATA);
  assign tgt_oe_o  = (state_q == ST_DEVS) || (state_q == ST_DATA) || (state_q == ST_TURN);
  assign rd_o      = (state_q == ST_DEVS) && !is_wr_i;
  assign wr_o      = (state_q == ST_TURN) && is_wr_i;
  assign ad_oe_o   = (state_q == ST_DATA) && !is_wr_i;
  assign par_oe_o  = (state_q == ST_TURN) && !is_wr_i;

  assert_stop_with_trdy_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !trdy_no |-> (!stop_no && !devsel_no));
  assert_trdy_after_devsel_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(trdy_no) |-> $past(!devsel_no));
  assert_wr_after_xfer_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_o |-> $past(!irdy_ni && !trdy_no));
  assert_strobe_excl_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({rd_o, wr_o}));
  assert_turnaround_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(xfer_o) |-> (tgt_oe_o && devsel_no && trdy_no && stop_no));
endmodule

// File: rtl/pci_tgt_data.sv
module pci_tgt_data #(
  parameter int DW  = 32,
  localparam int BEW = DW / 8
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           addr_ph_i,
  input  logic           dec_i,
  input  logic           rd_i,
  input  logic           xfer_i,
  input  logic           wchk_i,
  input  logic [DW-1:0]  ad_i,
  input  logic [BEW-1:0] cbe_ni,
  input  logic           idsel_i,
  input  logic           par_i,
  input  logic           par_chk_en_i,
  input  logic           perr_en_i,
  input  logic [DW-1:0]  rd_data_i,
  output logic [DW-1:0]  addr_o,
  output logic [BEW-1:0] cmd_o,
  output logic           idsel_o,
  output logic [DW-1:0]  ad_o,
  output logic           par_o,
  output logic [DW-1:0]  wr_data_o,
  output logic [BEW-1:0] wr_be_o,
  output logic           addr_perr_o,
  output logic           perr_no,
  output logic           perr_oe_o
);
  logic [DW-1:0]  rdata_q, wdata_q;
  logic [BEW-1:0] be_q;
  logic           apar_q, aerr_q, perr_q, perr_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_o  <= '0;
      cmd_o   <= '0;
      idsel_o <= 1'b0;
      apar_q  <= 1'b0;
      rdata_q <= '0;
      wdata_q <= '0;
      be_q    <= '0;
      aerr_q  <= 1'b0;
      perr_q  <= 1'b0;
      perr_d  <= 1'b0;
    end else begin
      if (addr_ph_i) begin
        addr_o  <= ad_i;
        cmd_o   <= cbe_ni;
        idsel_o <= idsel_i;
        apar_q  <= ^{ad_i, cbe_ni};
      end
      aerr_q <= dec_i && par_chk_en_i && (apar_q ^ par_i);
      if (rd_i) rdata_q <= rd_data_i;
      if (xfer_i) begin
        wdata_q <= ad_i;
        be_q    <= cbe_ni;
      end
      perr_q <= wchk_i && perr_en_i && (^{wdata_q, be_q, par_i});
      perr_d <= perr_q;
    end
  end

  assign ad_o        = rdata_q;
  assign par_o       = ^{rdata_q, be_q};
  assign wr_data_o   = wdata_q;
  assign wr_be_o     = ~be_q;
  assign addr_perr_o = aerr_q;
  assign perr_no     = !perr_q;
  assign perr_oe_o   = perr_q || perr_d;

  assert_perr_gated_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !perr_no |-> $past(perr_en_i));
  assert_aerr_pulse_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_perr_o |=> !addr_perr_o);
  assert_perr_oe_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !perr_no |-> perr_oe_o);
endmodule

// File: rtl/pci_tgt_ctrl.sv
module pci_tgt_ctrl
  import pci_tgt_pkg::*;
#(
  parameter int DW  = 32,
  localparam int BEW = DW / 8
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           frame_ni,
  input  logic           irdy_ni,
  input  logic           idsel_i,
  input  logic [BEW-1:0] cbe_ni,
  input  logic [DW-1:0]  ad_i,
  input  logic           par_i,
  output logic [DW-1:0]  ad_o,
  output logic           ad_oe_o,
  output logic           par_o,
  output logic           par_oe_o,
  output logic           devsel_no,
  output logic           trdy_no,
  output logic           stop_no,
  output logic           tgt_oe_o,
  output logic           perr_no,
  output logic           perr_oe_o,
  output logic           addr_perr_o,
  input  logic           par_chk_en_i,
  input  logic           perr_en_i,
  input  logic           io_hit_i,
  input  logic           mem_hit_i,
  input  logic           inta_en_i,
  output logic [DW-1:0]  acc_addr_o,
  output logic [3:0]     acc_cmd_o,
  output logic           rd_o,
  input  logic [DW-1:0]  rd_data_i,
  output logic           wr_o,
  output logic [DW-1:0]  wr_data_o,
  output logic [BEW-1:0] wr_be_o
);
  logic [BEW-1:0] cmd_q;
  logic           idsel_q, is_wr, claim;
  logic           addr_ph, dec, xfer, wchk;
  space_e         space;

  pci_cmd_decode u_dec (
    .cmd_i   (cmd_q[3:0]),
    .space_o (space),
    .is_wr_o (is_wr),
    .norm_o  (acc_cmd_o)
  );

  always_comb begin
    unique case (space)
      SP_IO:   claim = io_hit_i;
      SP_MEM:  claim = mem_hit_i;
      SP_CFG:  claim = idsel_q;
      SP_INTA: claim = inta_en_i;
      default: claim = 1'b0;  // broadcast and reserved never claim
    endcase
  end

  pci_tgt_fsm u_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .frame_ni  (frame_ni),
    .irdy_ni   (irdy_ni),
    .claim_i   (claim),
    .is_wr_i   (is_wr),
    .addr_ph_o (addr_ph),
    .dec_o     (dec),
    .xfer_o    (xfer),
    .wchk_o    (wchk),
    .devsel_no (devsel_no),
    .trdy_no   (trdy_no),
    .stop_no   (stop_no),
    .tgt_oe_o  (tgt_oe_o),
    .rd_o      (rd_o),
    .wr_o      (wr_o),
    .ad_oe_o   (ad_oe_o),
    .par_oe_o  (par_oe_o)
  );

  pci_tgt_data #(.DW(DW)) u_data (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .addr_ph_i    (addr_ph),
    .dec_i        (dec),
    .rd_i         (rd_o),
    .xfer_i       (xfer),
    .wchk_i       (wchk),
    .ad_i         (ad_i),
    .cbe_ni       (cbe_ni),
    .idsel_i      (idsel_i),
    .par_i        (par_i),
    .par_chk_en_i (par_chk_en_i),
    .perr_en_i    (perr_en_i),
    .rd_data_i    (rd_data_i),
    .addr_o       (acc_addr_o),
    .cmd_o        (cmd_q),
    .idsel_o      (idsel_q),
    .ad_o         (ad_o),
    .par_o        (par_o),
    .wr_data_o    (wr_data_o),
    .wr_be_o      (wr_be_o),
    .addr_perr_o  (addr_perr_o),
    .perr_no      (perr_no),
    .perr_oe_o    (perr_oe_o)
  );

  assert_claim_only_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(devsel_no) |-> $past(claim && dec));
  assert_ad_drive_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ad_oe_o |-> !trdy_no);
  assert_par_after_xfer_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    par_oe_o |-> $past(xfer));
endmodule

// File: tb/pci_tgt_ctrl_bench.sv
`timescale 1ns/1ps
module pci_tgt_ctrl_bench;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        frame_n = 1'b1, irdy_n = 1'b1, idsel = 1'b0, par = 1'b0;
  logic [3:0]  cbe_n = 4'hF;
  logic [31:0] ad = '0, rd_data = '0;
  logic        chk_en = 1'b0, perr_en = 1'b0, io_hit = 1'b0, mem_hit = 1'b0, inta_en = 1'b0;
  logic [31:0] ad_o, acc_addr, wr_data;
  logic [3:0]  acc_cmd, wr_be;
  logic        ad_oe, par_o, par_oe, devsel_n, trdy_n, stop_n, tgt_oe;
  logic        perr_n, perr_oe, aperr, rd, wr;
  int          errors = 0, checks = 0;

  always #2.5 clk = ~clk;

  pci_tgt_ctrl u_pci_tgt_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .frame_ni(frame_n), .irdy_ni(irdy_n),
    .idsel_i(idsel), .cbe_ni(cbe_n), .ad_i(ad), .par_i(par),
    .ad_o(ad_o), .ad_oe_o(ad_oe), .par_o(par_o), .par_oe_o(par_oe),
    .devsel_no(devsel_n), .trdy_no(trdy_n), .stop_no(stop_n), .tgt_oe_o(tgt_oe),
    .perr_no(perr_n), .perr_oe_o(perr_oe), .addr_perr_o(aperr),
    .par_chk_en_i(chk_en), .perr_en_i(perr_en), .io_hit_i(io_hit),
    .mem_hit_i(mem_hit), .inta_en_i(inta_en), .acc_addr_o(acc_addr),
    .acc_cmd_o(acc_cmd), .rd_o(rd), .rd_data_i(rd_data), .wr_o(wr),
    .wr_data_o(wr_data), .wr_be_o(wr_be)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  // one full cycle, driven and sampled on falling edges
  task automatic bus_cycle(input logic [3:0] cmd, input logic [31:0] addr, input logic sel,
                           input logic claim_exp, input logic [3:0] norm_exp,
                           input logic [31:0] wdata, input logic [3:0] be_n,
                           input logic bad_apar, input logic bad_dpar,
                           input logic [31:0] rdata, input int waits);
    logic is_wr;
    is_wr = cmd[0];
    frame_n = 1'b0; cbe_n = cmd; ad = addr; idsel = sel;
    tick();
    par = (^{addr, cmd}) ^ bad_apar;
    cbe_n = be_n; ad = is_wr ? wdata : 32'h0; rd_data = rdata; idsel = 1'b0;
    if (waits == 0) begin frame_n = 1'b1; irdy_n = 1'b0; end
    else            begin frame_n = 1'b0; irdy_n = 1'b1; end
    tick();
    chk("R1 acc_addr", acc_addr, addr);
    chk("R4 acc_cmd", {28'h0, acc_cmd}, {28'h0, norm_exp});
    chk("R10 addr_perr", {31'h0, aperr}, {31'h0, bad_apar & chk_en});
    if (!claim_exp) begin
      chk("R3 no claim oe", {31'h0, tgt_oe}, 32'h0);
      chk("R3 no rd", {31'h0, rd}, 32'h0);
      frame_n = 1'b1; irdy_n = 1'b1;
      for (int k = 0; k < 3; k++) begin
        tick();
        chk("R3 released", {29'h0, tgt_oe, wr, rd}, 32'h0);
      end
      return;
    end
    chk("R2 devsel", {30'h0, devsel_n, trdy_n}, 32'h1);
    chk("R7 rd strobe", {31'h0, rd}, {31'h0, !is_wr});
    tick();
    chk("R5 trdy+stop", {29'h0, devsel_n, trdy_n, stop_n}, 32'h0);
    chk("R5 ad_oe", {31'h0, ad_oe}, {31'h0, !is_wr});
    if (!is_wr) chk("R7 ad_o", ad_o, rdata);
    if (waits > 0) begin
      for (int k = 0; k < waits; k++) begin
        tick();
        chk("R6 trdy held", {30'h0, trdy_n, wr}, 32'h0);
      end
      frame_n = 1'b1; irdy_n = 1'b0;
    end
    tick();
    chk("R11 turnaround", {28'h0, tgt_oe, devsel_n, trdy_n, stop_n}, 32'hF);
    chk("R8 wr strobe", {31'h0, wr}, {31'h0, is_wr});
    if (is_wr) begin
      chk("R8 wr_data", wr_data, wdata);
      chk("R8 wr_be", {28'h0, wr_be}, {28'h0, ~be_n});
    end else begin
      chk("R7 par_oe", {31'h0, par_oe}, 32'h1);
      chk("R7 par_o", {31'h0, par_o}, {31'h0, ^{rdata, be_n}});
    end
    irdy_n = 1'b1;
    par = (^{wdata, be_n}) ^ bad_dpar;
    tick();
    chk("R11 released", {31'h0, tgt_oe}, 32'h0);
    chk("R9 perr", {30'h0, perr_n, perr_oe},
        (is_wr && bad_dpar && perr_en) ? 32'h1 : 32'h2);
    tick();
    par = 1'b0;
  endtask

  task automatic t_reset();
    chk("R12 oe", {28'h0, ad_oe, par_oe, tgt_oe, perr_oe}, 32'h0);
    chk("R12 ctl", {28'h0, devsel_n, trdy_n, stop_n, perr_n}, 32'hF);
    chk("R12 strobes", {29'h0, rd, wr, aperr}, 32'h0);
  endtask

  task automatic t_io();
    io_hit = 1'b1;
    bus_cycle(4'b0011, 32'h0000_0CF8, 0, 1, 4'b0011, 32'hA5A5_1234, 4'b0000, 0, 0, 0, 0); // R8
    bus_cycle(4'b0010, 32'h0000_0060, 0, 1, 4'b0010, 0, 4'b1110, 0, 0, 32'hDEAD_BEEF, 0); // R7
    bus_cycle(4'b0010, 32'h0000_0064, 0, 1, 4'b0010, 0, 4'b0000, 0, 0, 32'h0000_0001, 0); // R7 parity
    io_hit = 1'b0;
    bus_cycle(4'b0011, 32'h0000_0080, 0, 0, 4'b0011, 32'h1, 4'b0000, 0, 0, 0, 0); // R3 miss
  endtask

  task automatic t_mem_alias();
    mem_hit = 1'b1;
    bus_cycle(4'b0110, 32'h8000_0000, 0, 1, 4'b0110, 0, 4'b0000, 0, 0, 32'h1111_2222, 0); // R2
    bus_cycle(4'b1100, 32'h8000_0004, 0, 1, 4'b0110, 0, 4'b0000, 0, 0, 32'h3333_4444, 0); // R4
    bus_cycle(4'b1110, 32'h8000_0008, 0, 1, 4'b0110, 0, 4'b1100, 0, 0, 32'h5555_6666, 0); // R4
    bus_cycle(4'b1111, 32'h8000_000C, 0, 1, 4'b0111, 32'h7777_8888, 4'b0101, 0, 0, 0, 0); // R4
    mem_hit = 1'b0;
  endtask

  task automatic t_cfg_inta();
    bus_cycle(4'b1010, 32'h0000_0010, 1, 1, 4'b1010, 0, 4'b0000, 0, 0, 32'hCAFE_F00D, 0); // R2
    bus_cycle(4'b1011, 32'h0000_0014, 0, 0, 4'b1011, 32'h9, 4'b0000, 0, 0, 0, 0);          // R3
    inta_en = 1'b1;
    bus_cycle(4'b0000, 32'h0, 0, 1, 4'b0000, 0, 4'b0000, 0, 0, 32'h0000_0021, 0);           // R2
    inta_en = 1'b0;
    bus_cycle(4'b0000, 32'h0, 0, 0, 4'b0000, 0, 4'b0000, 0, 0, 0, 0);                       // R3
  endtask

  task automatic t_ignored();
    logic [3:0] cmds [6] = '{4'b0100, 4'b0101, 4'b1000, 4'b1001, 4'b1101, 4'b0001};
    io_hit = 1'b1; mem_hit = 1'b1; inta_en = 1'b1;
    foreach (cmds[i])
      bus_cycle(cmds[i], 32'h40 + i, 1, 0, cmds[i], 32'h5, 4'b0000, 0, 0, 0, 0); // R3
    io_hit = 1'b0; mem_hit = 1'b0; inta_en = 1'b0;
  endtask

  task automatic t_wait();
    io_hit = 1'b1;
    bus_cycle(4'b0011, 32'h0000_0300, 0, 1, 4'b0011, 32'h0BAD_CAFE, 4'b0011, 0, 0, 0, 3); // R6
    bus_cycle(4'b0010, 32'h0000_0304, 0, 1, 4'b0010, 0, 4'b0000, 0, 0, 32'h1357_9BDF, 2); // R6
    io_hit = 1'b0;
  endtask

  task automatic t_parity();
    io_hit = 1'b1;
    perr_en = 1'b1;
    bus_cycle(4'b0011, 32'h0000_0400, 0, 1, 4'b0011, 32'h0F0F_0F0F, 4'b0000, 0, 1, 0, 0); // R9
    bus_cycle(4'b0011, 32'h0000_0404, 0, 1, 4'b0011, 32'h0F0F_0F0E, 4'b0000, 0, 0, 0, 0); // R9 clean
    perr_en = 1'b0;
    bus_cycle(4'b0011, 32'h0000_0408, 0, 1, 4'b0011, 32'h0F0F_0F0F, 4'b0000, 0, 1, 0, 0); // R9 masked
    chk_en = 1'b1;
    bus_cycle(4'b0010, 32'h0000_040C, 0, 1, 4'b0010, 0, 4'b0000, 1, 0, 32'h2, 0);          // R10
    bus_cycle(4'b0010, 32'h0000_0410, 0, 1, 4'b0010, 0, 4'b0000, 0, 0, 32'h3, 0);          // R10 clean
    chk_en = 1'b0;
    bus_cycle(4'b0010, 32'h0000_0414, 0, 1, 4'b0010, 0, 4'b0000, 1, 0, 32'h4, 0);          // R10 off
    io_hit = 1'b0;
  endtask

  initial begin
    #(5.0 * 100000);
    errors++;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    repeat (3) tick();
    t_reset();
    rst_n = 1'b1;
    tick();
    t_reset();
    t_io();
    t_mem_alias();
    t_cfg_inta();
    t_ignored();
    t_wait();
    t_parity();
    repeat (2) tick();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule